// File: doc/BRIEF.md
# Two-Register Accumulator Processor Core

This block is a single-cycle 16-bit processor core. It holds an address register A, a data register D and a 15-bit program counter. Each clock it takes one instruction word from an instruction memory outside the block and one data word from a data memory outside the block. It then updates its registers and chooses the next program counter. Instruction fetch and data access use separate memories, so every instruction completes within one clock with no port sharing.

Two word formats are decoded. A word with a clear top bit loads a 15-bit constant into A. A word with a set top bit is a compute word. It selects the second ALU operand (A or the data-memory word) and sets the ALU operation. It names any subset of A, D and data memory as destinations, and gives a jump condition tested on the ALU result. Register A has two roles: its low bits form the data-memory address, and they also form the jump target.

Top module: `cpu_core`

## Requirements
- R1: Reset is synchronous and wins over every other PC update. At the clock edge where `reset` is high, PC, A and D become 0. While `reset` is high, `writeM` is low.
- R2: A word whose bit 15 is 0 loads A with `{1'b0, instruction[14:0]}`. This appears on `addressM` from the next cycle. The word never asserts `writeM`, leaves D unchanged and advances PC by 1.
- R3: A word whose bit 15 is 1 is a compute word, and bits 14 and 13 have no effect. The ALU x operand is always D. Bit 12 selects the y operand: 0 gives A and 1 gives `inM`.
- R4: Bits 11..6 control the ALU in the order zero-x, invert-x, zero-y, invert-y, function (1 = add, 0 = bitwise AND), invert-output. The result is seen on `outM`.
- R5: Bit 5 writes the ALU result into A, bit 4 writes it into D, and bit 3 stores it to data memory. A store drives `writeM` high for that cycle, with the result on `outM`.
- R6: `addressM` is the A value held at the start of the cycle. A compute word that writes both A and memory therefore stores to the old address.
- R7: Bit 2 jumps on a negative result, bit 1 on a zero result and bit 0 on a result that is neither zero nor negative. The conditions combine by OR, so 3'b111 always jumps and 3'b000 never does. A taken jump loads PC from the low 15 bits of the A value held at the start of the cycle.
- R8: When no jump is taken, PC increments by 1 and wraps from 32767 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| reset | input | 1 | Synchronous restart: PC, A and D go to 0 |
| instruction | input | 16 | Current instruction word, fetched at address `pc` |
| inM | input | 16 | Data-memory word read at `addressM` |
| outM | output | 16 | ALU result, the write data for a store |
| addressM | output | 15 | Data-memory address, taken from register A |
| writeM | output | 1 | Store strobe for the current cycle |
| pc | output | 15 | Address of the instruction being executed |

## Verification
A single compute word can store to memory and redirect the program counter in the same cycle. It can also write A while storing through the old A. In the first case the jump target and the store address are the same register, so a stale or early A value would show up in both places. The bench provokes these cases with directed words that store and jump together, or store and load A together, and also with several thousand random words. For each case a reference model built from the requirements predicts the address, the strobe, the data and the next PC, and these are compared with the ports.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    // Field positions of the compute word; the decoder relies on them.
    localparam int KIND_BIT  = 15;
    localparam int YSEL_BIT  = 12;
    localparam int OP_HI     = 11;
    localparam int OP_LO     = 6;
    localparam int DST_A_BIT = 5;
    localparam int DST_D_BIT = 4;
    localparam int DST_M_BIT = 3;
    localparam int JMP_NEG   = 2;
    localparam int JMP_ZERO  = 1;
    localparam int JMP_POS   = 0;

    // ALU control word, one bit per stage of the operand conditioning chain.
    typedef struct packed {
        logic zero_x;
        logic inv_x;
        logic zero_y;
        logic inv_y;
        logic use_add;
        logic inv_out;
    } alu_op_t;

    // Decoded fields of one instruction word.
    typedef struct packed {
        logic      is_imm;
        logic      y_from_mem;
        alu_op_t   op;
        logic      wr_a;
        logic      wr_d;
        logic      wr_mem;
        logic      on_neg;
        logic      on_zero;
        logic      on_pos;
    } ctrl_t;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  alu_op_t      op,
    output logic [W-1:0] result,
    output logic         is_zero,
    output logic         is_neg
);

    logic [W-1:0] x_z, x_c, y_z, y_c, raw;

    always_comb begin
        x_z    = op.zero_x  ? '0    : x_in;
        x_c    = op.inv_x   ? ~x_z  : x_z;
        y_z    = op.zero_y  ? '0    : y_in;
        y_c    = op.inv_y   ? ~y_z  : y_z;
        raw    = op.use_add ? (x_c + y_c) : (x_c & y_c);
        result = op.inv_out ? ~raw  : raw;
    end

    assign is_zero = (result == '0);
    assign is_neg  = result[W-1];

endmodule

// File: rtl/cpu_decode.sv
module cpu_decode
    import cpu_pkg::*;
#(
    parameter int W = 16,
    localparam int IMM_W = W - 1
) (
    input  logic [W-1:0]     word,
    output ctrl_t            ctrl,
    output logic [IMM_W-1:0] imm_val
);

    always_comb begin
        ctrl            = '0;
        ctrl.is_imm     = ~word[KIND_BIT];
        ctrl.y_from_mem = word[YSEL_BIT];
        ctrl.op         = alu_op_t'(word[OP_HI:OP_LO]);
        // An immediate word carries no destination and no jump.
        if (word[KIND_BIT]) begin
            ctrl.wr_a    = word[DST_A_BIT];
            ctrl.wr_d    = word[DST_D_BIT];
            ctrl.wr_mem  = word[DST_M_BIT];
            ctrl.on_neg  = word[JMP_NEG];
            ctrl.on_zero = word[JMP_ZERO];
            ctrl.on_pos  = word[JMP_POS];
        end
    end

    assign imm_val = word[IMM_W-1:0];

endmodule

// File: rtl/cpu_branch.sv
module cpu_branch
    import cpu_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  is_zero,
    input  logic  is_neg,
    output logic  take
);

    logic is_pos;

    assign is_pos = ~is_zero & ~is_neg;
    assign take   = (ctrl.on_neg  & is_neg)
                  | (ctrl.on_zero & is_zero)
                  | (ctrl.on_pos  & is_pos);

endmodule

// File: rtl/cpu_core.sv
module cpu_core
    import cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int ADDR_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              reset,
    input  logic [DATA_W-1:0] instruction,
    input  logic [DATA_W-1:0] inM,
    output logic [DATA_W-1:0] outM,
    output logic [ADDR_W-1:0] addressM,
    output logic              writeM,
    output logic [ADDR_W-1:0] pc
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [ADDR_W-1:0] pc;
    } core_state_t;

    core_state_t       st_d, st_q;
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] imm_val;
    logic [DATA_W-1:0] y_opnd, alu_res;
    logic              alu_zero, alu_neg, take;

    cpu_decode #(.W(DATA_W)) u_dec (
        .word    (instruction),
        .ctrl    (ctrl),
        .imm_val (imm_val)
    );

    assign y_opnd = ctrl.y_from_mem ? inM : st_q.a;

    cpu_alu #(.W(DATA_W)) u_alu (
        .x_in    (st_q.d),
        .y_in    (y_opnd),
        .op      (ctrl.op),
        .result  (alu_res),
        .is_zero (alu_zero),
        .is_neg  (alu_neg)
    );

    cpu_branch u_br (
        .ctrl    (ctrl),
        .is_zero (alu_zero),
        .is_neg  (alu_neg),
        .take    (take)
    );

    always_comb begin
        st_d = st_q;
        if (reset) begin
            st_d = '0;
        end else begin
            if (ctrl.is_imm) begin
                st_d.a = {1'b0, imm_val};
            end else if (ctrl.wr_a) begin
                st_d.a = alu_res;
            end
            if (ctrl.wr_d) begin
                st_d.d = alu_res;
            end
            st_d.pc = take ? st_q.a[ADDR_W-1:0] : (st_q.pc + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign outM     = alu_res;
    assign addressM = st_q.a[ADDR_W-1:0];
    assign writeM   = ctrl.wr_mem & ~reset;
    assign pc       = st_q.pc;

endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk #(
    parameter int DATA_W = 16,
    localparam int ADDR_W = DATA_W - 1
) (
    input logic              clk,
    input logic              reset,
    input logic [DATA_W-1:0] instruction,
    input logic [ADDR_W-1:0] addressM,
    input logic              writeM,
    input logic [ADDR_W-1:0] pc
);

    a_r1_reset_clears: assert property (@(posedge clk)
        reset |=> (pc == '0 && addressM == '0));

    a_r1_no_store_in_reset: assert property (@(posedge clk)
        reset |-> !writeM);

    a_r2_imm_loads_a: assert property (@(posedge clk) disable iff (reset)
        !instruction[DATA_W-1] |=> addressM == $past(instruction[ADDR_W-1:0]));

    a_r2_imm_no_store: assert property (@(posedge clk) disable iff (reset)
        !instruction[DATA_W-1] |-> !writeM);

    a_r8_imm_steps_pc: assert property (@(posedge clk) disable iff (reset)
        !instruction[DATA_W-1] |=> pc == ADDR_W'($past(pc) + 1'b1));

    a_r5_store_strobe: assert property (@(posedge clk) disable iff (reset)
        (instruction[DATA_W-1] && instruction[3]) |-> writeM);

    a_r7_always_jump: assert property (@(posedge clk) disable iff (reset)
        (instruction[DATA_W-1] && instruction[2:0] == 3'b111) |=> pc == $past(addressM));

endmodule

bind cpu_core cpu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .reset       (reset),
    .instruction (instruction),
    .addressM    (addressM),
    .writeM      (writeM),
    .pc          (pc)
);

// File: tb/tb_cpu_core.sv
`timescale 1ns/1ps
module tb_cpu_core;

    logic        clk = 1'b0;
    logic        reset = 1'b1;
    logic [15:0] instruction = 16'h0000;
    logic [15:0] inM = 16'h0000;
    logic [15:0] outM;
    logic [14:0] addressM;
    logic        writeM;
    logic [14:0] pc;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mA = '0, mD = '0;
    logic [14:0] mPC = '0;

    always #10 clk = ~clk;

    cpu_core dut (
        .clk(clk), .reset(reset), .instruction(instruction), .inM(inM),
        .outM(outM), .addressM(addressM), .writeM(writeM), .pc(pc)
    );

    function automatic logic [15:0] alu_ref(input logic [15:0] x, input logic [15:0] y,
                                            input logic [5:0] c);
        logic [15:0] xv, yv, r;
        xv = c[5] ? 16'h0 : x;  xv = c[4] ? ~xv : xv;
        yv = c[3] ? 16'h0 : y;  yv = c[2] ? ~yv : yv;
        r  = c[1] ? xv + yv : xv & yv;
        return c[0] ? ~r : r;
    endfunction

    function automatic logic [15:0] cw(input logic a, input logic [5:0] op,
                                       input logic [2:0] dst, input logic [2:0] jmp);
        return {3'b111, a, op, dst, jmp};
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One instruction: drive at the falling edge, compare before the rising edge.
    task automatic step(input logic [15:0] ins, input logic [15:0] m, input string tag);
        logic [15:0] y, r, nA, nD;
        logic [14:0] nPC;
        logic wr, zr, ng, tk;
        @(negedge clk);
        instruction = ins;
        inM = m;
        #5;
        nA = mA; nD = mD; wr = 1'b0; r = 16'h0;
        if (!ins[15]) begin
            nA  = {1'b0, ins[14:0]};
            nPC = mPC + 1'b1;
        end else begin
            y  = ins[12] ? m : mA;
            r  = alu_ref(mD, y, ins[11:6]);
            wr = ins[3];
            zr = (r == 16'h0);
            ng = r[15];
            tk = (ins[2] & ng) | (ins[1] & zr) | (ins[0] & ~zr & ~ng);
            nPC = tk ? mA[14:0] : mPC + 1'b1;
            if (ins[5]) nA = r;
            if (ins[4]) nD = r;
        end
        chk(pc == mPC, tag, "pc", pc, mPC);
        chk(addressM == mA[14:0], tag, "addressM", addressM, mA[14:0]);
        chk(writeM == wr, tag, "writeM", writeM, wr);
        if (wr) chk(outM == r, tag, "outM", outM, r);
        @(posedge clk);
        #1;
        mA = nA; mD = nD; mPC = nPC;
    endtask

    task automatic do_reset(input logic [15:0] ins);
        @(negedge clk);
        reset = 1'b1;
        instruction = ins;
        #5;
        chk(writeM == 1'b0, "R1", "writeM in reset", writeM, 0);
        @(posedge clk);
        #1;
        mA = '0; mD = '0; mPC = '0;
        chk(pc == 15'd0, "R1", "pc after reset", pc, 0);
        chk(addressM == 15'd0, "R1", "addressM after reset", addressM, 0);
        @(negedge clk);
        reset = 1'b0;
        #1;
        mA = '0; mD = '0; mPC = '0;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (2) @(posedge clk);
        // R1: reset with a store-and-jump word present
        do_reset(cw(1'b0, 6'b001100, 3'b001, 3'b111));

        // R2: immediate load, then D from A, then D unchanged by a later immediate
        step(16'h0064, 16'h0, "R2");
        step(cw(1'b0, 6'b110000, 3'b010, 3'b000), 16'h0, "R4");
        step(16'h0005, 16'h0, "R2");
        step(cw(1'b0, 6'b001100, 3'b001, 3'b000), 16'h0, "R2");   // M=D must give 0x64

        // R6: store and load A together goes to old address
        step(16'h0007, 16'h0, "R2");
        step(cw(1'b0, 6'b000010, 3'b101, 3'b000), 16'h0, "R6");
        step(cw(1'b0, 6'b110000, 3'b001, 3'b000), 16'h0, "R6");  // address now 0x6B

        // R3: y from memory, bits 14:13 ignored
        step(cw(1'b1, 6'b000010, 3'b011, 3'b000), 16'h0010, "R3");
        step(16'h0FFF | 16'h0000, 16'h0, "R2");
        step(16'h9000 | {4'b0000, cw(1'b1, 6'b000010, 3'b011, 3'b000)} [11:0], 16'h0010, "R3");
        step(16'hF000 | {4'b0000, cw(1'b1, 6'b000010, 3'b011, 3'b000)} [11:0], 16'h0010, "R3");

        // R4: a spread of ALU operations
        foreach (ops_list[k]) step(cw(1'b0, ops_list[k], 3'b001, 3'b000), 16'h0, "R4");

        // R7: every jump code on negative, zero and positive results
        for (int s = 0; s < 3; s++) begin
            for (int j = 0; j < 8; j++) begin
                step(16'h0032, 16'h0, "R2");
                step(cw(1'b0, (s == 0) ? 6'b111010 : (s == 1) ? 6'b101010 : 6'b111111,
                        3'b000, j[2:0]), 16'h0, "R7");
            end
        end

        // R5 with R7: store and unconditional jump in one word
        step(16'h0009, 16'h0, "R2");
        step(cw(1'b0, 6'b111111, 3'b001, 3'b111), 16'h0, "R5");
        step(16'h0000, 16'h0, "R7");

        // R8: PC wrap at the top of the space
        step(16'h7FFF, 16'h0, "R2");
        step(cw(1'b0, 6'b101010, 3'b000, 3'b111), 16'h0, "R7");
        step(16'h0001, 16'h0, "R8");
        step(16'h0002, 16'h0, "R8");

        // R1: reset wins over a taken jump
        step(16'h0123, 16'h0, "R2");
        do_reset(cw(1'b0, 6'b101010, 3'b000, 3'b111));

        // Random words mixed with immediates
        seed = $urandom(32'h5EED_C0DE);
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if ($urandom % 2 == 0) w[15] = 1'b0;
            step(w, 16'($urandom), w[15] ? "R5" : "R2");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    logic [5:0] ops_list [12] = '{6'b000010, 6'b010011, 6'b000111, 6'b000000,
                                  6'b010101, 6'b011111, 6'b110111, 6'b001110,
                                  6'b110010, 6'b001111, 6'b110011, 6'b001101};

endmodule